// File: doc/BRIEF.md
# Configurable Logic Tile with Routing

This block is a single logic tile of a small island-style programmable fabric. Sixteen single-length wire ends arrive at the tile, one of each index 0 to 3 from each of the north, south, east and west sides. The tile drives sixteen departing wire beginnings and evaluates one 4-input lookup table. An 84-bit configuration word sets its behaviour. Every departing wire has a small routing mux. It may take the same-index wire arriving on one of the other three sides, or the table output. Each of the four table inputs may take any of the sixteen arriving wires.

The configuration is loaded in one of two ways. The first is a serial port that shifts bits into a staging register, MSB first. A commit pulse then copies the staging register into the active configuration. The second is a parallel port that writes the active configuration in one cycle. Once the active word is set, all outputs follow the wire ends combinationally, with no clock in the data path. Tiles are tiled and wired together at array level, which is outside this block.

Top module: `logic_tile`

## Requirements
- R1: After reset the active configuration is all zero, so every departing wire and the table output are 0 whatever the wire ends carry.
- R2: While `cfg_shift_en` is high, the staging register shifts left one bit per clock and takes in `cfg_shift_bit`, so an 84-bit word goes in MSB first over 84 cycles. The active configuration and all outputs do not change until `cfg_commit` is sampled high. The staged word then takes effect at that clock edge.
- R3: A cycle with `cfg_par_load` high writes `cfg_par_word` into the active configuration at that edge. It takes priority over a `cfg_commit` in the same cycle, and it leaves the staging register untouched.
- R4: Configuration bit layout, from bit 83 downward:
  - Sixteen 3-bit routing fields take route slot j = side*4 + index at bits [83-3j : 81-3j], with sides ordered N=0, S=1, E=2, W=3.
  - Four 5-bit table-input fields take input i at bits [35-5i : 31-5i].
  - The 16-bit truth table sits at [15:0].
- R5: For routing code 1 to 3, the beginning takes the same-index end from the three other sides, listed in the order N, S, E, W with the beginning's own side removed. Code 1 is the first side left in that list, code 3 the last. Code 4 selects the table output.
- R6: Routing codes 0, 5, 6 and 7 drive the departing wire to 0.
- R7: Table-input code c from 1 to 16 selects arriving end c-1 in the order NEND0..3, SEND0..3, EEND0..3, WEND0..3. Codes 0 and 17 to 31 feed 0.
- R8: Form p = {IN3,IN2,IN1,IN0}. The table output is truth-table bit 15-p, so position 0 of the written string (bit 15) is the all-zero case and the final position (bit 0) is the all-ones case.
- R9: Outputs respond to wire-end changes within the same cycle, with no clock edge needed.
- R10: No routing code ever lets a departing wire carry the end arriving on its own side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_shift_en | input | 1 | Shift one bit into staging |
| cfg_shift_bit | input | 1 | Serial configuration data, MSB first |
| cfg_commit | input | 1 | Copy staging into active configuration |
| cfg_par_load | input | 1 | Write the parallel word into active configuration |
| cfg_par_word | input | 84 | Parallel configuration word |
| wire_end_n | input | 4 | Ends arriving from the north, index 0..3 |
| wire_end_s | input | 4 | Ends arriving from the south |
| wire_end_e | input | 4 | Ends arriving from the east |
| wire_end_w | input | 4 | Ends arriving from the west |
| wire_beg_n | output | 4 | Beginnings leaving to the north |
| wire_beg_s | output | 4 | Beginnings leaving to the south |
| wire_beg_e | output | 4 | Beginnings leaving to the east |
| wire_beg_w | output | 4 | Beginnings leaving to the west |
| lut_out | output | 1 | Lookup table output |

## Verification
The bench goes through every routing slot with every code. It drives only the expected source high, and then everything except that source. A design that swapped the skip order of the sides, or let the own-side end through, would set the wrong beginning, or would stay 0 where 1 is expected. It checks the truth-table bit order with asymmetric tables: a reversed index would turn AND into NOR-like behaviour. It also checks that codes above the legal range read as OFF rather than wrapping onto a source. For loading, it shows that a staged word stays invisible until commit. It also shows that a parallel write wins over a simultaneous commit, while the staged word survives for a later commit.

// File: rtl/tile_pkg.sv
package tile_pkg;
    parameter int SIDES    = 4;
    parameter int WIRES    = 4;
    parameter int ROUTE_W  = 3;
    parameter int SEL_W    = 5;
    parameter int LUT_K    = 4;
    localparam int LUT_BITS = 1 << LUT_K;
    localparam int ROUTES   = SIDES * WIRES;
    localparam int NSRC     = SIDES * WIRES;
    localparam int CFG_W    = ROUTES * ROUTE_W + LUT_K * SEL_W + LUT_BITS;

    localparam logic [ROUTE_W-1:0] RCODE_OFF = '0;
    localparam logic [ROUTE_W-1:0] RCODE_LUT = ROUTE_W'(4);

    typedef struct packed {
        logic [ROUTES-1:0][ROUTE_W-1:0] route;   // slot j at index ROUTES-1-j
        logic [LUT_K-1:0][SEL_W-1:0]    in_sel;  // input i at index LUT_K-1-i
        logic [LUT_BITS-1:0]            tt;
    } tile_cfg_t;
endpackage

// File: rtl/tile_cfg_store.sv
module tile_cfg_store
    import tile_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic             commit,
    input  logic             par_load,
    input  logic [CFG_W-1:0] par_word,
    output logic [CFG_W-1:0] stage_o,
    output logic [CFG_W-1:0] active_o
);
    typedef struct packed {
        logic [CFG_W-1:0] stage;
        logic [CFG_W-1:0] active;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.stage = {st_q.stage[CFG_W-2:0], shift_bit};
        end
        if (par_load) begin
            st_d.active = par_word;
        end else if (commit) begin
            st_d.active = st_q.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_o  = st_q.stage;
    assign active_o = st_q.active;
endmodule

// File: rtl/tile_route_mux.sv
module tile_route_mux
    import tile_pkg::*;
(
    input  logic [ROUTE_W-1:0] code,
    input  logic [2:0]         cand,     // legal ends, N,S,E,W order, own side removed
    input  logic               lut_y,
    output logic               beg
);
    always_comb begin
        unique case (code)
            ROUTE_W'(1): beg = cand[0];
            ROUTE_W'(2): beg = cand[1];
            ROUTE_W'(3): beg = cand[2];
            RCODE_LUT:   beg = lut_y;
            default:     beg = 1'b0;
        endcase
    end
endmodule

// File: rtl/tile_lut_in_mux.sv
module tile_lut_in_mux
    import tile_pkg::*;
(
    input  logic [SEL_W-1:0] code,
    input  logic [NSRC-1:0]  ends,
    output logic             y
);
    localparam int IDX_W = $clog2(NSRC);

    always_comb begin
        if (code != '0 && code <= SEL_W'(NSRC)) begin
            y = ends[IDX_W'(code - SEL_W'(1))];
        end else begin
            y = 1'b0;
        end
    end
endmodule

// File: rtl/tile_lut.sv
module tile_lut
    import tile_pkg::*;
(
    input  logic [LUT_BITS-1:0] tt,
    input  logic [LUT_K-1:0]    sel,
    output logic                y
);
    logic [LUT_K-1:0] pos;

    always_comb begin
        pos = LUT_K'(LUT_BITS - 1) - sel;
        y   = tt[pos];
    end
endmodule

// File: rtl/logic_tile.sv
module logic_tile
    import tile_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift_en,
    input  logic             cfg_shift_bit,
    input  logic             cfg_commit,
    input  logic             cfg_par_load,
    input  logic [CFG_W-1:0] cfg_par_word,
    input  logic [WIRES-1:0] wire_end_n,
    input  logic [WIRES-1:0] wire_end_s,
    input  logic [WIRES-1:0] wire_end_e,
    input  logic [WIRES-1:0] wire_end_w,
    output logic [WIRES-1:0] wire_beg_n,
    output logic [WIRES-1:0] wire_beg_s,
    output logic [WIRES-1:0] wire_beg_e,
    output logic [WIRES-1:0] wire_beg_w,
    output logic             lut_out
);
    logic [CFG_W-1:0]            cfg_stage;
    logic [CFG_W-1:0]            cfg_active;
    tile_cfg_t                   cfg_f;
    logic [SIDES-1:0][WIRES-1:0] end_arr;
    logic [SIDES-1:0][WIRES-1:0] beg_arr;
    logic [NSRC-1:0]             end_flat;
    logic [LUT_K-1:0]            lut_sel;
    logic                        lut_y;

    tile_cfg_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (cfg_shift_en),
        .shift_bit (cfg_shift_bit),
        .commit    (cfg_commit),
        .par_load  (cfg_par_load),
        .par_word  (cfg_par_word),
        .stage_o   (cfg_stage),
        .active_o  (cfg_active)
    );

    assign cfg_f      = tile_cfg_t'(cfg_active);
    assign end_arr[0] = wire_end_n;
    assign end_arr[1] = wire_end_s;
    assign end_arr[2] = wire_end_e;
    assign end_arr[3] = wire_end_w;
    assign end_flat   = end_arr;   // bit side*WIRES+k

    for (genvar i = 0; i < LUT_K; i++) begin : g_in
        tile_lut_in_mux u_in (
            .code (cfg_f.in_sel[LUT_K-1-i]),
            .ends (end_flat),
            .y    (lut_sel[i])
        );
    end

    tile_lut u_lut (
        .tt  (cfg_f.tt),
        .sel (lut_sel),
        .y   (lut_y)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int SRC0 = (s == 0) ? 1 : 0;
        localparam int SRC1 = (s <= 1) ? 2 : 1;
        localparam int SRC2 = (s <= 2) ? 3 : 2;
        for (genvar k = 0; k < WIRES; k++) begin : g_wire
            logic [2:0] cand;
            assign cand = {end_arr[SRC2][k], end_arr[SRC1][k], end_arr[SRC0][k]};
            tile_route_mux u_rt (
                .code  (cfg_f.route[ROUTES-1-(s*WIRES+k)]),
                .cand  (cand),
                .lut_y (lut_y),
                .beg   (beg_arr[s][k])
            );
        end
    end

    assign wire_beg_n = beg_arr[0];
    assign wire_beg_s = beg_arr[1];
    assign wire_beg_e = beg_arr[2];
    assign wire_beg_w = beg_arr[3];
    assign lut_out    = lut_y;
endmodule

// File: rtl/tile_checker.sv
module tile_checker
    import tile_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_shift_en,
    input logic             cfg_shift_bit,
    input logic             cfg_commit,
    input logic             cfg_par_load,
    input logic [CFG_W-1:0] cfg_par_word,
    input logic [CFG_W-1:0] cfg_stage,
    input logic [CFG_W-1:0] cfg_active,
    input logic [WIRES-1:0] wire_beg_n,
    input logic [WIRES-1:0] wire_beg_s,
    input logic [WIRES-1:0] wire_beg_e,
    input logic [WIRES-1:0] wire_beg_w,
    input logic             lut_out
);
    logic [ROUTE_W-1:0] n0_code;
    assign n0_code = cfg_active[CFG_W-1 -: ROUTE_W];

    p_zero_cfg_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_active == '0) |-> ({wire_beg_n, wire_beg_s, wire_beg_e, wire_beg_w} == '0 && !lut_out));

    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift_en |=> cfg_stage == {$past(cfg_stage[CFG_W-2:0]), $past(cfg_shift_bit)});

    p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_commit && !cfg_par_load) |=> cfg_active == $past(cfg_stage));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_commit && !cfg_par_load) |=> $stable(cfg_active));

    p_par_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_par_load |=> cfg_active == $past(cfg_par_word));

    p_par_keeps_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_par_load && !cfg_shift_en) |=> $stable(cfg_stage));

    p_off_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (n0_code == RCODE_OFF || n0_code > RCODE_LUT) |-> !wire_beg_n[0]);
endmodule

bind logic_tile tile_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_shift_en  (cfg_shift_en),
    .cfg_shift_bit (cfg_shift_bit),
    .cfg_commit    (cfg_commit),
    .cfg_par_load  (cfg_par_load),
    .cfg_par_word  (cfg_par_word),
    .cfg_stage     (cfg_stage),
    .cfg_active    (cfg_active),
    .wire_beg_n    (wire_beg_n),
    .wire_beg_s    (wire_beg_s),
    .wire_beg_e    (wire_beg_e),
    .wire_beg_w    (wire_beg_w),
    .lut_out       (lut_out)
);

// File: tb/sim_logic_tile.sv
`timescale 1ns/1ps
module sim_logic_tile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_shift_en = 1'b0;
    logic        cfg_shift_bit = 1'b0;
    logic        cfg_commit = 1'b0;
    logic        cfg_par_load = 1'b0;
    logic [83:0] cfg_par_word = '0;
    logic [15:0] ends_all = '0;
    logic [3:0]  wire_beg_n, wire_beg_s, wire_beg_e, wire_beg_w;
    logic        lut_out;
    logic [15:0] beg_all;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    logic_tile u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_shift_en  (cfg_shift_en),
        .cfg_shift_bit (cfg_shift_bit),
        .cfg_commit    (cfg_commit),
        .cfg_par_load  (cfg_par_load),
        .cfg_par_word  (cfg_par_word),
        .wire_end_n    (ends_all[3:0]),
        .wire_end_s    (ends_all[7:4]),
        .wire_end_e    (ends_all[11:8]),
        .wire_end_w    (ends_all[15:12]),
        .wire_beg_n    (wire_beg_n),
        .wire_beg_s    (wire_beg_s),
        .wire_beg_e    (wire_beg_e),
        .wire_beg_w    (wire_beg_w),
        .lut_out       (lut_out)
    );

    assign beg_all = {wire_beg_w, wire_beg_e, wire_beg_s, wire_beg_n};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [83:0] put_route(logic [83:0] w, int j, logic [2:0] c);
        w[83-3*j -: 3] = c;
        return w;
    endfunction

    function automatic logic [83:0] put_in(logic [83:0] w, int i, logic [4:0] c);
        w[35-5*i -: 5] = c;
        return w;
    endfunction

    task automatic apply_cfg(input logic [83:0] w);
        @(negedge clk);
        cfg_par_load = 1'b1;
        cfg_par_word = w;
        @(negedge clk);
        cfg_par_load = 1'b0;
    endtask

    task automatic drive_sample(input logic [15:0] e);
        @(negedge clk);
        ends_all = e;
        #2;
    endtask

    task automatic t_reset;
        ends_all = 16'hFFFF;
        #5;
        chk(beg_all == 16'h0 && !lut_out, "R1 outputs in reset", {15'h0, lut_out, beg_all}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive_sample(16'hFFFF);
        chk(beg_all == 16'h0 && !lut_out, "R1 outputs after reset", {15'h0, lut_out, beg_all}, 32'h0);
    endtask

    task automatic t_serial;
        logic [83:0] w;
        apply_cfg('0);
        w = put_route('0, 15, 3'd4);
        w[15:0] = 16'hFFFF;
        for (int b = 0; b < 84; b++) begin
            @(negedge clk);
            cfg_shift_en  = 1'b1;
            cfg_shift_bit = w[83-b];
            if (b == 40) chk(beg_all == 16'h0, "R2 mid-shift hidden", {16'h0, beg_all}, 32'h0);
        end
        @(negedge clk);
        cfg_shift_en = 1'b0;
        #2;
        chk(beg_all == 16'h0 && !lut_out, "R2 staged before commit", {15'h0, lut_out, beg_all}, 32'h0);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
        #2;
        chk(beg_all == 16'h8000, "R2 R4 commit WBEG3 from table", {16'h0, beg_all}, 32'h8000);
        chk(lut_out == 1'b1, "R4 truth table field at low bits", {31'h0, lut_out}, 32'h1);
    endtask

    task automatic t_priority;
        @(negedge clk);
        cfg_commit   = 1'b1;
        cfg_par_load = 1'b1;
        cfg_par_word = '0;
        @(negedge clk);
        cfg_commit   = 1'b0;
        cfg_par_load = 1'b0;
        #2;
        chk(beg_all == 16'h0 && !lut_out, "R3 parallel beats commit", {15'h0, lut_out, beg_all}, 32'h0);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
        #2;
        chk(beg_all == 16'h8000, "R3 staging kept by parallel write", {16'h0, beg_all}, 32'h8000);
    endtask

    task automatic t_route;
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 4; k++) begin
                int j = s*4 + k;
                for (int c = 1; c <= 3; c++) begin
                    int src = ((c-1) < s) ? (c-1) : c;
                    logic [15:0] one = 16'(1) << (src*4 + k);
                    apply_cfg(put_route('0, j, 3'(c)));
                    drive_sample(one);
                    chk(beg_all == (16'(1) << j), "R5 R9 source high", {16'h0, beg_all}, 32'(16'(1) << j));
                    drive_sample(~one);
                    chk(beg_all == 16'h0, "R5 R9 source low", {16'h0, beg_all}, 32'h0);
                end
                begin
                    logic [83:0] w = put_route('0, j, 3'd4);
                    w[15:0] = 16'hFFFF;
                    apply_cfg(w);
                    drive_sample(16'h0);
                    chk(beg_all == (16'(1) << j), "R5 table output one", {16'h0, beg_all}, 32'(16'(1) << j));
                    w[15:0] = 16'h0;
                    apply_cfg(w);
                    drive_sample(16'hFFFF);
                    chk(beg_all == 16'h0, "R5 table output zero", {16'h0, beg_all}, 32'h0);
                end
            end
        end
    endtask

    task automatic t_off;
        logic [2:0] codes [4] = '{3'd0, 3'd5, 3'd6, 3'd7};
        for (int j = 0; j < 16; j++) begin
            for (int c = 0; c < 4; c++) begin
                logic [83:0] w = put_route('0, j, codes[c]);
                w[15:0] = 16'hFFFF;
                apply_cfg(w);
                drive_sample(16'hFFFF);
                chk(beg_all == 16'h0, "R6 off codes drive zero", {16'h0, beg_all}, 32'h0);
            end
        end
    endtask

    task automatic t_own_side;
        for (int j = 0; j < 16; j++) begin
            for (int c = 0; c < 8; c++) begin
                apply_cfg(put_route('0, j, 3'(c)));
                drive_sample(16'hF << ((j/4)*4));
                chk(beg_all == 16'h0, "R10 own side blocked", {16'h0, beg_all}, 32'h0);
            end
        end
    endtask

    task automatic t_lut_inputs;
        logic [4:0] offc [3] = '{5'd0, 5'd17, 5'd31};
        for (int i = 0; i < 4; i++) begin
            logic [15:0] tt = '0;
            for (int p = 0; p < 16; p++) tt[15-p] = 1'((p >> i) & 1);
            for (int c = 1; c <= 16; c++) begin
                logic [83:0] w = put_in('0, i, 5'(c));
                w[15:0] = tt;
                apply_cfg(w);
                drive_sample(16'(1) << (c-1));
                chk(lut_out == 1'b1, "R7 selected end high", {31'h0, lut_out}, 32'h1);
                drive_sample(~(16'(1) << (c-1)));
                chk(lut_out == 1'b0, "R7 selected end low", {31'h0, lut_out}, 32'h0);
            end
            for (int c = 0; c < 3; c++) begin
                logic [83:0] w = put_in('0, i, offc[c]);
                w[15:0] = tt;
                apply_cfg(w);
                drive_sample(16'hFFFF);
                chk(lut_out == 1'b0, "R7 off input code", {31'h0, lut_out}, 32'h0);
            end
        end
    endtask

    task automatic t_truth;
        logic [15:0] tabs [3] = '{16'h0001, 16'h8000, 16'hA5C3};
        for (int t = 0; t < 3; t++) begin
            logic [83:0] w = '0;
            for (int i = 0; i < 4; i++) w = put_in(w, i, 5'(i + 1));
            w[15:0] = tabs[t];
            apply_cfg(w);
            for (int p = 0; p < 16; p++) begin
                drive_sample(16'(p));
                chk(lut_out == tabs[t][15-p], "R8 truth table order", {31'h0, lut_out}, {31'h0, tabs[t][15-p]});
            end
        end
    endtask

    initial begin
        #(20.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_serial();
        t_priority();
        t_route();
        t_off();
        t_own_side();
        t_lut_inputs();
        t_truth();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule